// File: doc/BRIEF.md
# Line-Count Field Sync Generator

This block sits beside a transport-stream capture port and turns a stream of byte-valid strobes into a field sync signal. Accepted bytes are grouped into lines of a programmable width; the default is 376 bytes, which is a pair of 188-byte packets. Lines are grouped into fields of a programmable line count; the default is 512 lines. The sync output goes high when the first byte of the final line of each field is accepted. It goes low again when the last byte of that line is accepted. The output is routed back to the capture port's vertical-sync input, so each field boundary starts a new DMA frame.

A one-cycle line pulse marks the end of every line. A saturating 14-bit counter records how many times the sync output has toggled since the generator was enabled. While the enable input is low, everything is held cleared and the sync output stays low. The programmed width and line count are copied into working registers only while the block is disabled or at a field boundary. A change made mid-field therefore never distorts the field in progress.

Top module: `fsync_gen`

## Requirements
- R1: After reset, syncOut, lineEvent and eventCount are all zero.
- R2: While enable is low, syncOut, lineEvent and eventCount are zero on the following cycle and the byte and line position restart at zero. Disabling while syncOut is high drives it low on the next cycle.
- R3: syncOut becomes 1 in the cycle after the first byte of line T-1 of a field is accepted. Lines are numbered from 0 and T is the effective threshold.
- R4: syncOut becomes 0 in the cycle after the last byte of line T-1 is accepted, which is byte W*T-1 of the field. It is 0 after every other byte outside that line, and the pattern repeats every field.
- R5: A byte is accepted only on a cycle with enable and byteValid both high. Cycles without an accepted byte leave syncOut and eventCount unchanged and keep lineEvent low.
- R6: lineEvent is high for exactly the one cycle after the last byte of each line, and low otherwise.
- R7: eventCount rises by one on every 0-to-1 and every 1-to-0 change of syncOut while enabled. It saturates at 16383 (all 14 bits set).
- R8: lineWidth and lineThresh are captured on a cycle where enable is low, or on the cycle that accepts the last byte of a field. Changes at other times first affect the next field.
- R9: A lineThresh of 0 behaves as 1, and a lineWidth of 0 or 1 behaves as 2. Lines and fields are therefore never degenerate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable; low clears and holds the generator |
| byteValid | input | 1 | One transport-stream byte is present this cycle |
| lineWidth | input | 12 | Bytes per line (default use 376) |
| lineThresh | input | 12 | Lines per field (default use 512) |
| syncOut | output | 1 | Field sync fed back to the capture port |
| lineEvent | output | 1 | One-cycle pulse after each completed line |
| eventCount | output | 14 | Saturating count of syncOut transitions |

## Verification
The assertions take the clamped width to be at least two bytes, so two line ends can never fall on consecutive cycles. They also assume that enable and byteValid are synchronous to clk. They put no limit on the timing of configuration changes, because the working copy moves only at a field edge or while the block is idle.

The stimulus includes out-of-range settings (width 1, threshold 0) so that the clamp is exercised. It mixes seeded random gaps in byteValid with long gap-free runs. It also rewrites the configuration in the middle of a field, and drops enable while syncOut is high.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  // Strobes passed from the counting control to the output datapath
  typedef struct packed {
    logic take;      // a byte is accepted this cycle
    logic lineEnd;   // accepted byte closes a line
    logic fieldEnd;  // accepted byte closes a field
    logic rise;      // accepted byte opens the last line of the field
    logic fall;      // accepted byte closes the last line of the field
  } fsync_strb_t;
endpackage

// File: rtl/fsync_ctrl.sv
module fsync_ctrl
  import fsync_pkg::*;
#(
  parameter int WIDTH_W  = 12,
  parameter int THRESH_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                byteValid,
  input  logic [WIDTH_W-1:0]  activeWidth,
  input  logic [THRESH_W-1:0] activeThresh,
  output fsync_strb_t         strb
);
  logic [WIDTH_W-1:0]  byteCnt;
  logic [THRESH_W-1:0] lineCnt;
  logic lastByte, lastLine, firstByte, take;

  assign take      = enable & byteValid;
  assign lastByte  = (byteCnt == activeWidth - WIDTH_W'(1));
  assign lastLine  = (lineCnt == activeThresh - THRESH_W'(1));
  assign firstByte = (byteCnt == '0);

  always_comb begin
    strb.take     = take;
    strb.lineEnd  = take & lastByte;
    strb.fieldEnd = take & lastByte & lastLine;
    strb.rise     = take & firstByte & lastLine;
    strb.fall     = take & lastByte & lastLine;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      byteCnt <= '0;
      lineCnt <= '0;
    end else if (take) begin
      if (lastByte) begin
        byteCnt <= '0;
        lineCnt <= lastLine ? '0 : lineCnt + THRESH_W'(1);
      end else begin
        byteCnt <= byteCnt + WIDTH_W'(1);
      end
    end
  end

  // Position counters stay inside the working line and field size (R9 clamp keeps them non-empty)
  assert_byte_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt < activeWidth);
  assert_line_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    lineCnt < activeThresh);
  // Counters restart after a disabled cycle
  assert_restart_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (byteCnt == '0 && lineCnt == '0));
endmodule

// File: rtl/fsync_dp.sv
module fsync_dp
  import fsync_pkg::*;
#(
  parameter int WIDTH_W  = 12,
  parameter int THRESH_W = 12,
  parameter int CNT_W    = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic [WIDTH_W-1:0]  cfgWidth,
  input  logic [THRESH_W-1:0] cfgThresh,
  input  fsync_strb_t         strb,
  output logic [WIDTH_W-1:0]  activeWidth,
  output logic [THRESH_W-1:0] activeThresh,
  output logic                syncOut,
  output logic                lineEvent,
  output logic [CNT_W-1:0]    eventCount
);
  localparam logic [CNT_W-1:0]    CNT_MAX   = '1;
  localparam logic [WIDTH_W-1:0]  MIN_WIDTH = WIDTH_W'(2);
  localparam logic [THRESH_W-1:0] MIN_LINES = THRESH_W'(1);

  logic [WIDTH_W-1:0]  widthClamp;
  logic [THRESH_W-1:0] threshClamp;
  logic                toggle;

  assign widthClamp  = (cfgWidth < MIN_WIDTH) ? MIN_WIDTH : cfgWidth;
  assign threshClamp = (cfgThresh == '0) ? MIN_LINES : cfgThresh;
  assign toggle      = (strb.rise & ~syncOut) | (strb.fall & syncOut);

  // Working configuration: loaded while idle or at a field boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeWidth  <= MIN_WIDTH;
      activeThresh <= MIN_LINES;
    end else if (!enable || strb.fieldEnd) begin
      activeWidth  <= widthClamp;
      activeThresh <= threshClamp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      syncOut    <= 1'b0;
      lineEvent  <= 1'b0;
      eventCount <= '0;
    end else begin
      lineEvent <= strb.lineEnd;
      if (strb.rise)      syncOut <= 1'b1;
      else if (strb.fall) syncOut <= 1'b0;
      if (toggle && eventCount != CNT_MAX) eventCount <= eventCount + CNT_W'(1);
    end
  end

  assert_sync_low_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!syncOut && !lineEvent && eventCount == '0));
  assert_gap_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !strb.take) |=> ($stable(syncOut) && $stable(eventCount) && !lineEvent));
  assert_line_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    lineEvent |=> !lineEvent);
  assert_count_sat_R7: assert property (@(posedge clk) disable iff (!rstN)
    (enable && eventCount == CNT_MAX) |=> eventCount == CNT_MAX);
  assert_count_mono_R7: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> eventCount >= $past(eventCount));
  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !strb.fieldEnd) |=> ($stable(activeWidth) && $stable(activeThresh)));
  assert_cfg_min_R9: assert property (@(posedge clk) disable iff (!rstN)
    activeWidth >= MIN_WIDTH && activeThresh >= MIN_LINES);
endmodule

// File: rtl/fsync_gen.sv
module fsync_gen #(
  parameter int WIDTH_W  = 12,
  parameter int THRESH_W = 12,
  parameter int CNT_W    = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                byteValid,
  input  logic [WIDTH_W-1:0]  lineWidth,
  input  logic [THRESH_W-1:0] lineThresh,
  output logic                syncOut,
  output logic                lineEvent,
  output logic [CNT_W-1:0]    eventCount
);
  fsync_pkg::fsync_strb_t strb;
  logic [WIDTH_W-1:0]  activeWidth;
  logic [THRESH_W-1:0] activeThresh;

  fsync_ctrl #(.WIDTH_W(WIDTH_W), .THRESH_W(THRESH_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .byteValid(byteValid),
    .activeWidth(activeWidth), .activeThresh(activeThresh), .strb(strb));

  fsync_dp #(.WIDTH_W(WIDTH_W), .THRESH_W(THRESH_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .enable(enable),
    .cfgWidth(lineWidth), .cfgThresh(lineThresh), .strb(strb),
    .activeWidth(activeWidth), .activeThresh(activeThresh),
    .syncOut(syncOut), .lineEvent(lineEvent), .eventCount(eventCount));

  // Sync may only rise in the cycle after an accepted byte (R3)
  assert_rise_on_byte_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!syncOut && !(enable && byteValid)) |=> !syncOut);
endmodule

// File: tb/sim_fsync_gen.sv
module sim_fsync_gen;
  localparam int WW = 12, TW = 12, CW = 14;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, enable = 1'b0, byteValid = 1'b0;
  logic [WW-1:0] lineWidth = 12'd376;
  logic [TW-1:0] lineThresh = 12'd2;
  logic syncOut, lineEvent;
  logic [CW-1:0] eventCount;

  fsync_gen u0 (.clk(clk), .rstN(rstN), .enable(enable), .byteValid(byteValid),
    .lineWidth(lineWidth), .lineThresh(lineThresh),
    .syncOut(syncOut), .lineEvent(lineEvent), .eventCount(eventCount));

  int errors = 0, checks = 0;
  int mW = 2, mT = 1, lp = 0, ln = 0, expCnt = 0;
  bit expSync = 0, expLine = 0, done = 0;

  function automatic int clampW(int w); return (w < 2) ? 2 : w; endfunction
  function automatic int clampT(int t); return (t == 0) ? 1 : t; endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit en, bit v, string tag);
    bit prev;
    @(negedge clk);
    enable = en; byteValid = v;
    @(posedge clk); #1;
    if (!en) begin
      lp = 0; ln = 0; expSync = 0; expLine = 0; expCnt = 0;
      mW = clampW(int'(lineWidth)); mT = clampT(int'(lineThresh));
    end else if (v) begin
      prev = expSync;
      expLine = (lp == mW - 1);
      expSync = (ln == mT - 1) && (lp != mW - 1);
      if (expSync != prev && expCnt < CMAX) expCnt++;
      if (lp == mW - 1) begin
        lp = 0;
        if (ln == mT - 1) begin
          ln = 0; mW = clampW(int'(lineWidth)); mT = clampT(int'(lineThresh));
        end else ln++;
      end else lp++;
    end else begin
      expLine = 0;
    end
    chk(syncOut == expSync, tag, expSync ? "R3 sync high" : "R4 sync low", syncOut, expSync);
    chk(lineEvent == expLine, tag, "R6 lineEvent", lineEvent, expLine);
    chk(int'(eventCount) == expCnt, tag, "R7 eventCount", eventCount, expCnt);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    chk(syncOut == 0, "R1", "reset syncOut", syncOut, 0);
    chk(lineEvent == 0, "R1", "reset lineEvent", lineEvent, 0);
    chk(eventCount == 0, "R1", "reset eventCount", eventCount, 0);
    @(negedge clk); rstN = 1'b1;

    // Two fields of 376-byte lines, two lines per field, no gaps
    lineWidth = 12'd376; lineThresh = 12'd2;
    step(0, 0, "R2");
    for (int i = 0; i < 1504; i++) step(1, 1, "R3");

    // Random gaps, small geometry
    lineWidth = 12'd5; lineThresh = 12'd3;
    step(0, 0, "R2");
    for (int i = 0; i < 400; i++) step(1, ($urandom % 2) == 0, "R5");

    // Degenerate settings clamp
    lineWidth = 12'd1; lineThresh = 12'd0;
    step(0, 0, "R9");
    step(1, 1, "R9");
    chk(syncOut == 1, "R9", "first byte raises sync with threshold 0", syncOut, 1);
    step(1, 1, "R9");
    chk(lineEvent == 1, "R9", "line of two bytes ends", lineEvent, 1);
    for (int i = 0; i < 40; i++) step(1, 1, "R9");

    // Mid-field reconfiguration
    lineWidth = 12'd4; lineThresh = 12'd3;
    step(0, 0, "R8");
    for (int i = 0; i < 6; i++) step(1, 1, "R8");
    lineWidth = 12'd7; lineThresh = 12'd2;
    for (int i = 0; i < 120; i++) step(1, ($urandom % 4) != 0, "R8");

    // Disable while sync high
    lineWidth = 12'd4; lineThresh = 12'd2;
    step(0, 0, "R2");
    for (int i = 0; i < 6; i++) step(1, 1, "R2");
    chk(syncOut == 1, "R2", "sync high before disable", syncOut, 1);
    step(0, 1, "R2");
    chk(syncOut == 0 && eventCount == 0, "R2", "disable clears sync", syncOut, 0);
    for (int i = 0; i < 20; i++) step(1, 1, "R2");

    // Saturation of the transition counter
    lineWidth = 12'd2; lineThresh = 12'd1;
    step(0, 0, "R7");
    for (int i = 0; i < 16400; i++) step(1, 1, "R7");
    chk(int'(eventCount) == CMAX, "R7", "saturated count", eventCount, CMAX);
    step(1, 0, "R5");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule